// File: doc/BRIEF.md
# Vector Load Address Sequencer

This block turns one vectorised load request into a stream of memory requests. Each request is a byte address paired with a destination register number. A single load configuration covers three addressing modes. In unit-stride mode the step between accesses is the element size. In constant-stride mode the step comes from a register value. In indexed mode each element's offset is read from a vector of per-element index values. Each element may span several consecutive destination registers (a segment), and the segment registers of one element are visited at successive multiples of the stride.

A pulse on `start` while the block is idle captures the whole configuration: base, sizes, mode bits, predicate mask and index values. The block then walks the elements. Elements that the predicate disables produce no requests at all. Requests leave over a valid/ready handshake. A single-cycle `done` marks the end of the walk, and the block is then ready for the next load.

Top module: `vld_addr_seq`

## Requirements
- R1: While reset is applied and after it is released, with no start, `req_valid`, `done` and `busy` are low.
- R2: With `idx_vec`=0 and `stride_sel`=0 (unit stride), element i, segment register j is requested at address base + (i*(seg_len+1) + j) * elem_size.
- R3: With `idx_vec`=0 and `stride_sel`=1 (constant stride), the address is base + (i*(seg_len+1) + j) * stride_val.
- R4: With `idx_vec`=1 (indexed, whatever `stride_sel` is), the address is base + idx[i] + j*stride. Here idx[i] is bits [32*i+31:32*i] of `idx_vals`, and stride is elem_size if `stride_sel`=0, else stride_val.
- R5: Requests come in element-major order, with j running 0..seg_len fastest, and `req_reg` = (dest_reg + j) mod 32.
- R6: With `pred_en`=1 and bit i of `pred_mask` clear, element i issues no request for any of its segment registers. With `pred_en`=0 every element is issued.
- R7: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_reg` hold their values into the next cycle.
- R8: `done` is high for one cycle, after the last request has been accepted and every remaining element has been passed over. With vec_len 0 it is high in the first cycle after start is taken. `busy` is low in the cycle after `done`.
- R9: The configuration is sampled only when start is taken while idle. Later changes on the configuration inputs, and start pulses while `busy` is high, leave the request stream unchanged.
- R10: A vec_len above MAX_VL (8) is treated as MAX_VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load walk when idle |
| base_addr | input | 32 | Base byte address |
| elem_size | input | 8 | Element size in bytes (unit stride) |
| stride_val | input | 32 | Stride register value (constant stride) |
| stride_sel | input | 1 | 0: element stride, 1: constant stride |
| idx_vec | input | 1 | Index source is a vector: indexed mode |
| seg_len | input | 3 | Segment length minus one |
| vec_len | input | 4 | Number of elements |
| dest_reg | input | 5 | First destination register |
| pred_en | input | 1 | Predication enabled for the destination |
| pred_mask | input | 8 | Per-element predicate bits |
| idx_vals | input | 256 | Per-element index values, element i at bits 32*i+31:32*i |
| req_ready | input | 1 | Consumer accepts the current request |
| req_valid | output | 1 | Request present |
| req_addr | output | 32 | Request byte address |
| req_reg | output | 5 | Request destination register |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | Single-cycle end-of-walk pulse |

## Verification
The assertions check on every cycle that a stalled request holds its address and register, and that nothing is requested or finished while idle. They also check that the register number stays inside the segment window above the destination, and that the block is idle after `done`. The address arithmetic for each mode can only be shown by the bench's scenarios. The same goes for skipping masked elements, the clamp on vector length, ignoring start pulses mid-walk, and the exact cycle of `done`. The bench compares each accepted request against a stream it builds from the configuration.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [1:0] {
    VAG_UNIT  = 2'd0,
    VAG_CONST = 2'd1,
    VAG_INDEX = 2'd2
  } vag_mode_e;

  typedef enum logic {
    VAG_IDLE = 1'b0,
    VAG_RUN  = 1'b1
  } vag_state_e;
endpackage

// File: rtl/vag_mode_sel.sv
module vag_mode_sel
  import vag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ESZ_W  = 8,
  parameter int SEG_W  = 3
) (
  input  logic              stride_sel,
  input  logic              idx_vec,
  input  logic [ESZ_W-1:0]  elem_size,
  input  logic [ADDR_W-1:0] stride_val,
  input  logic [SEG_W-1:0]  seg_len,
  output vag_mode_e         mode,
  output logic [ADDR_W-1:0] stride,
  output logic [ADDR_W-1:0] elem_step
);
  logic [SEG_W:0] seg_cnt;

  always_comb begin
    if (idx_vec)         mode = VAG_INDEX;
    else if (stride_sel) mode = VAG_CONST;
    else                 mode = VAG_UNIT;
    stride    = stride_sel ? stride_val : ADDR_W'(elem_size);
    seg_cnt   = {1'b0, seg_len} + (SEG_W+1)'(1);
    elem_step = stride * ADDR_W'(seg_cnt);
  end
endmodule

// File: rtl/vag_idx_store.sv
module vag_idx_store #(
  parameter int ADDR_W = 32,
  parameter int MAX_VL = 8,
  parameter int VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_en,
  input  logic [MAX_VL*ADDR_W-1:0] idx_in,
  input  logic [VL_W-1:0]          rd_sel,
  output logic [ADDR_W-1:0]        rd_data
);
  logic [ADDR_W-1:0] idx_q [MAX_VL];

  for (genvar g = 0; g < MAX_VL; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       idx_q[g] <= '0;
      else if (load_en) idx_q[g] <= idx_in[g*ADDR_W +: ADDR_W];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < MAX_VL; k++) begin
      if (rd_sel == VL_W'(k)) rd_data = idx_q[k];
    end
  end
endmodule

// File: rtl/vag_seq.sv
module vag_seq
  import vag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MAX_VL = 8,
  parameter int SEG_W  = 3,
  parameter int REG_W  = 5,
  parameter int VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [ADDR_W-1:0] first_off,
  input  vag_mode_e         mode_in,
  input  logic [ADDR_W-1:0] stride_in,
  input  logic [ADDR_W-1:0] step_in,
  input  logic [SEG_W-1:0]  seg_in,
  input  logic [VL_W-1:0]   vl_in,
  input  logic              pen_in,
  input  logic [MAX_VL-1:0] mask_in,
  input  logic [REG_W-1:0]  dest_in,
  input  logic [ADDR_W-1:0] idx_next,
  output logic [VL_W-1:0]   idx_sel,
  output logic              load_en,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [REG_W-1:0]  req_reg,
  output logic              busy,
  output logic              done
);
  localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);

  vag_state_e        state_q, state_d;
  logic [VL_W-1:0]   elem_q, elem_d;
  logic [SEG_W-1:0]  seg_q, seg_d;
  logic [ADDR_W-1:0] ebase_q, ebase_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [SEG_W-1:0]  lim_q;
  logic [VL_W-1:0]   vl_q, vl_eff;
  vag_mode_e         mode_q;
  logic [ADDR_W-1:0] stride_q, step_q, base_q;
  logic              pen_q;
  logic [MAX_VL-1:0] mask_q;
  logic [REG_W-1:0]  dest_q;

  logic run, in_range, mask_bit, active, last_seg, fire, advance, step;
  logic state_en, walk_en;
  logic [ADDR_W-1:0] first_addr, next_base;

  always_comb begin
    run      = (state_q == VAG_RUN);
    in_range = (elem_q < vl_q);
    mask_bit = 1'b0;
    for (int k = 0; k < MAX_VL; k++) begin
      if (elem_q == VL_W'(k)) mask_bit = mask_q[k];
    end
    active    = !pen_q || mask_bit;
    req_valid = run && in_range && active;
    done      = run && !in_range;
    busy      = run;
    load_en   = !run && start;
    last_seg  = (seg_q == lim_q);
    fire      = req_valid && req_ready;
    advance   = run && in_range && (!active || (fire && last_seg));
    step      = fire && !last_seg;
    idx_sel   = elem_q + VL_W'(1);
    vl_eff    = (vl_in > VL_CAP) ? VL_CAP : vl_in;
    first_addr = base_in + first_off;
    next_base  = (mode_q == VAG_INDEX) ? (base_q + idx_next) : (ebase_q + step_q);
    req_addr  = addr_q;
    req_reg   = dest_q + REG_W'(seg_q);
  end

  always_comb begin
    state_d = state_q;
    elem_d  = elem_q;
    seg_d   = seg_q;
    ebase_d = ebase_q;
    addr_d  = addr_q;
    if (load_en) begin
      state_d = VAG_RUN;
      elem_d  = '0;
      seg_d   = '0;
      ebase_d = first_addr;
      addr_d  = first_addr;
    end else if (done) begin
      state_d = VAG_IDLE;
    end else if (advance) begin
      elem_d  = elem_q + VL_W'(1);
      seg_d   = '0;
      ebase_d = next_base;
      addr_d  = next_base;
    end else if (step) begin
      seg_d  = seg_q + SEG_W'(1);
      addr_d = addr_q + stride_q;
    end
    state_en = load_en || done;
    walk_en  = load_en || advance || step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= VAG_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_q  <= '0;
      seg_q   <= '0;
      ebase_q <= '0;
      addr_q  <= '0;
    end else if (walk_en) begin
      elem_q  <= elem_d;
      seg_q   <= seg_d;
      ebase_q <= ebase_d;
      addr_q  <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q    <= '0;
      vl_q     <= '0;
      mode_q   <= VAG_UNIT;
      stride_q <= '0;
      step_q   <= '0;
      base_q   <= '0;
      pen_q    <= 1'b0;
      mask_q   <= '0;
      dest_q   <= '0;
    end else if (load_en) begin
      lim_q    <= seg_in;
      vl_q     <= vl_eff;
      mode_q   <= mode_in;
      stride_q <= stride_in;
      step_q   <= step_in;
      base_q   <= base_in;
      pen_q    <= pen_in;
      mask_q   <= mask_in;
      dest_q   <= dest_in;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_reg)));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!req_valid && !done));

  p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_stay_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_reg_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (REG_W'(req_reg - dest_q) <= REG_W'(lim_q)));
endmodule

// File: rtl/vld_addr_seq.sv
module vld_addr_seq
  import vag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MAX_VL = 8,
  parameter int ESZ_W  = 8,
  parameter int SEG_W  = 3,
  parameter int REG_W  = 5,
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        base_addr,
  input  logic [ESZ_W-1:0]         elem_size,
  input  logic [ADDR_W-1:0]        stride_val,
  input  logic                     stride_sel,
  input  logic                     idx_vec,
  input  logic [SEG_W-1:0]         seg_len,
  input  logic [VL_W-1:0]          vec_len,
  input  logic [REG_W-1:0]         dest_reg,
  input  logic                     pred_en,
  input  logic [MAX_VL-1:0]        pred_mask,
  input  logic [MAX_VL*ADDR_W-1:0] idx_vals,
  input  logic                     req_ready,
  output logic                     req_valid,
  output logic [ADDR_W-1:0]        req_addr,
  output logic [REG_W-1:0]         req_reg,
  output logic                     busy,
  output logic                     done
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  vag_mode_e         mode;
  logic [ADDR_W-1:0] stride, elem_step, first_off, idx_next;
  logic [VL_W-1:0]   idx_sel;
  logic              load_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i   = rst_sync_q[1];
  assign first_off = idx_vec ? idx_vals[ADDR_W-1:0] : '0;

  vag_mode_sel #(.ADDR_W(ADDR_W), .ESZ_W(ESZ_W), .SEG_W(SEG_W)) u_mode (
    .stride_sel (stride_sel),
    .idx_vec    (idx_vec),
    .elem_size  (elem_size),
    .stride_val (stride_val),
    .seg_len    (seg_len),
    .mode       (mode),
    .stride     (stride),
    .elem_step  (elem_step)
  );

  vag_idx_store #(.ADDR_W(ADDR_W), .MAX_VL(MAX_VL), .VL_W(VL_W)) u_idx (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .load_en (load_en),
    .idx_in  (idx_vals),
    .rd_sel  (idx_sel),
    .rd_data (idx_next)
  );

  vag_seq #(.ADDR_W(ADDR_W), .MAX_VL(MAX_VL), .SEG_W(SEG_W), .REG_W(REG_W), .VL_W(VL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .start     (start),
    .base_in   (base_addr),
    .first_off (first_off),
    .mode_in   (mode),
    .stride_in (stride),
    .step_in   (elem_step),
    .seg_in    (seg_len),
    .vl_in     (vec_len),
    .pen_in    (pred_en),
    .mask_in   (pred_mask),
    .dest_in   (dest_reg),
    .idx_next  (idx_next),
    .idx_sel   (idx_sel),
    .load_en   (load_en),
    .req_ready (req_ready),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_reg   (req_reg),
    .busy      (busy),
    .done      (done)
  );
endmodule

// File: tb/vld_addr_seq_bench.sv
module vld_addr_seq_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] base;
    logic [7:0]  esz;
    logic [31:0] strd;
    logic        sel;
    logic        ivec;
    logic [2:0]  seg;
    logic [3:0]  vl;
    logic        pen;
    logic [7:0]  mask;
    logic [4:0]  dest;
    logic        stall;
    logic        poke;
  } case_t;

  localparam int NCASE = 8;
  localparam case_t CASES [NCASE] = '{
    '{32'h0000_1000, 8'd4, 32'h0,     1'b0, 1'b0, 3'd0, 4'd5,  1'b0, 8'h00,       5'd3,  1'b0, 1'b0}, // R2
    '{32'h0000_2000, 8'd8, 32'h0,     1'b0, 1'b0, 3'd2, 4'd3,  1'b0, 8'h00,       5'd30, 1'b1, 1'b0}, // R2 R5 wrap R7
    '{32'h0001_0000, 8'd4, 32'h40,    1'b1, 1'b0, 3'd1, 4'd4,  1'b1, 8'b0000_1010, 5'd8,  1'b1, 1'b0}, // R3 R6
    '{32'h0003_0000, 8'd2, 32'h0,     1'b0, 1'b1, 3'd1, 4'd6,  1'b1, 8'b0011_0101, 5'd4,  1'b0, 1'b0}, // R4 R6
    '{32'h0004_0000, 8'd4, 32'h100,   1'b1, 1'b1, 3'd0, 4'd8,  1'b0, 8'h00,       5'd1,  1'b1, 1'b0}, // R4
    '{32'h0000_0500, 8'd1, 32'h0,     1'b0, 1'b0, 3'd0, 4'd12, 1'b0, 8'h00,       5'd0,  1'b0, 1'b0}, // R10
    '{32'h0000_0700, 8'd4, 32'h0,     1'b0, 1'b0, 3'd1, 4'd4,  1'b1, 8'h00,       5'd2,  1'b0, 1'b0}, // R6 all masked
    '{32'h0005_0000, 8'd4, 32'h20,    1'b1, 1'b0, 3'd1, 4'd3,  1'b0, 8'h00,       5'd6,  1'b1, 1'b1}  // R9
  };

  logic         clk = 1'b0;
  logic         rst_n, start, stride_sel, idx_vec, pred_en, req_ready;
  logic [31:0]  base_addr, stride_val;
  logic [7:0]   elem_size, pred_mask;
  logic [2:0]   seg_len;
  logic [3:0]   vec_len;
  logic [4:0]   dest_reg;
  logic [255:0] idx_vals;
  logic         req_valid, busy, done;
  logic [31:0]  req_addr;
  logic [4:0]   req_reg;

  int checks = 0;
  int bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vld_addr_seq u_vld_addr_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .elem_size(elem_size), .stride_val(stride_val), .stride_sel(stride_sel),
    .idx_vec(idx_vec), .seg_len(seg_len), .vec_len(vec_len), .dest_reg(dest_reg),
    .pred_en(pred_en), .pred_mask(pred_mask), .idx_vals(idx_vals),
    .req_ready(req_ready), .req_valid(req_valid), .req_addr(req_addr),
    .req_reg(req_reg), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] idx_of(input int k, input logic [2:0] seg);
    return 32'((7 - k) * 24 + 8 * int'(seg));
  endfunction

  task automatic run_case(input case_t c);
    logic [31:0] ea [64];
    logic [4:0]  er [64];
    int ne = 0;
    int got = 0;
    int vle;
    logic [31:0] st;
    logic [31:0] off;
    bit prev_stall = 1'b0;
    logic [31:0] prev_addr = '0;
    logic [4:0]  prev_reg = '0;
    bit seen_done = 1'b0;
    string tag;
    tag = c.ivec ? "R4" : (c.sel ? "R3" : "R2");
    vle = (int'(c.vl) > 8) ? 8 : int'(c.vl);
    st  = c.sel ? c.strd : 32'(c.esz);
    for (int i = 0; i < vle; i++) begin
      if (!c.pen || c.mask[i]) begin
        off = c.ivec ? idx_of(i, c.seg) : 32'(i * (int'(c.seg) + 1)) * st;
        for (int j = 0; j <= int'(c.seg); j++) begin
          ea[ne] = c.base + off + 32'(j) * st;
          er[ne] = c.dest + 5'(j);
          ne++;
        end
      end
    end
    @(negedge clk);
    base_addr = c.base; elem_size = c.esz; stride_val = c.strd;
    stride_sel = c.sel; idx_vec = c.ivec; seg_len = c.seg; vec_len = c.vl;
    dest_reg = c.dest; pred_en = c.pen; pred_mask = c.mask;
    for (int k = 0; k < 8; k++) idx_vals[k*32 +: 32] = idx_of(k, c.seg);
    start = 1'b1;
    for (int t = 0; t < 300 && !seen_done; t++) begin
      @(negedge clk);
      if (c.poke && t == 0) begin
        start = 1'b1; base_addr = 32'hDEAD_0000; stride_val = 32'h4; seg_len = 3'd0;
      end else begin
        start = 1'b0;
      end
      req_ready = c.stall ? ((cyc % 3) != 0) : 1'b1;
      #1;
      if (c.poke && t == 0) check(busy == 1'b1, "R9", "busy during poke", 32'(busy), 32'h1);
      if (prev_stall) begin
        check(req_valid && req_addr == prev_addr && req_reg == prev_reg, "R7",
              "held request", req_addr, prev_addr);
      end
      prev_stall = req_valid && !req_ready;
      prev_addr  = req_addr;
      prev_reg   = req_reg;
      if (req_valid && req_ready) begin
        if (got < ne) begin
          check(req_addr == ea[got], c.poke ? "R9" : tag, "address", req_addr, ea[got]);
          check(req_reg == er[got], "R5", "register", 32'(req_reg), 32'(er[got]));
        end else begin
          check(1'b0, "R6", "surplus request", 32'(got), 32'(ne));
        end
        got++;
      end
      if (done) begin
        seen_done = 1'b1;
        check(got == ne && !req_valid, "R8", "requests before done", 32'(got), 32'(ne));
      end
    end
    check(seen_done, "R8", "done seen", 32'(seen_done), 32'h1);
    @(negedge clk);
    #1;
    check(!done && !busy, "R8", "idle after done", {30'b0, done, busy}, 32'h0);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    bad++;
    checks++;
    $display("FAIL watchdog expired: actual=%0d expected<%0d", wd, 100000);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; req_ready = 1'b0;
    base_addr = '0; elem_size = '0; stride_val = '0; stride_sel = 1'b0;
    idx_vec = 1'b0; seg_len = '0; vec_len = '0; dest_reg = '0;
    pred_en = 1'b0; pred_mask = '0; idx_vals = '0;
    repeat (3) @(negedge clk);
    #1;
    check(!req_valid && !done && !busy, "R1", "outputs in reset",
          {29'b0, req_valid, done, busy}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(!req_valid && !done && !busy, "R1", "outputs after reset",
          {29'b0, req_valid, done, busy}, 32'h0);

    for (int n = 0; n < NCASE; n++) run_case(CASES[n]);

    // R8: zero-length walk
    @(negedge clk);
    vec_len = 4'd0; pred_en = 1'b0; start = 1'b1; req_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    check(done && !req_valid, "R8", "done right after start at vl 0",
          {30'b0, done, req_valid}, 32'h2);
    @(negedge clk);
    #1;
    check(!done && !busy, "R8", "single done pulse at vl 0", {30'b0, done, busy}, 32'h0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule